// File: doc/BRIEF.md
# Load Address Hazard Gate

This block sits next to the reorder buffer and decides, each cycle, whether a load whose effective address is already computed may start its memory access. It looks at every reorder-buffer slot that holds a store. It blocks the load if any live store that is older than the load targets the same word address. It also blocks the load if any such store has not yet computed its address. Stores write memory only when they retire from the head of the reorder buffer, so write-after-write and write-after-read ordering through memory needs no check here. This block guards read-after-write ordering only.

Age is taken relative to the head pointer. Slot `i` has age `(i - head) mod ENTRIES`. A store is older than the load when its age is strictly smaller than the age of the load's own slot. Slots that a flush kills in the current cycle drop out of the comparison in that same cycle. The verdict is purely combinational. Once the blocking store retires and its valid bit falls, the load is released in the same cycle. `ENTRIES` must be a power of two so that the age subtraction wraps naturally.

Top module: `ld_hazard_gate`

## Requirements
- R1: While `loadValid` is 0, both `loadGo` and `loadStall` are 0.
- R2: When `loadValid` is 1 and a live, older store has a known address equal to `loadAddr`, `loadStall` is 1 and `loadGo` is 0. A live store has `stValid`=1 and `killMask`=0.
- R3: When `loadValid` is 1 and a live, older store has `addrKnown`=0, `loadStall` is 1 and `loadGo` is 0, whatever its address field holds.
- R4: When `loadValid` is 1 and every live, older store has a known address different from `loadAddr`, `loadGo` is 1 and `loadStall` is 0.
- R5: Stores whose age is equal to or greater than the load's age are ignored, even if their address matches or is unknown. When `loadTag` equals `head`, the load always gets `loadGo`=1.
- R6: Age wraps around the buffer. With `head`=6 and `loadTag`=1 in an 8-slot buffer, slots 6, 7 and 0 are older and slots 2 to 5 are younger.
- R7: A slot whose `killMask` bit is 1 is excluded from the comparison in the same cycle.
- R8: A slot whose `stValid` bit is 0 is excluded, so `loadGo` rises in the same cycle that the blocking store's valid bit falls.
- R9: While `loadValid` is 1, exactly one of `loadGo` and `loadStall` is 1.
- R10: Addresses are compared on all `ADDR_W` bits. A store address that differs from the load address only in bit 0 or only in the top bit does not block the load.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; used only by the attached property checker |
| rstN | input | 1 | Active-low reset; used only by the attached property checker |
| head | input | TAG_W | Slot index of the oldest reorder-buffer entry |
| stValid | input | ENTRIES | Per slot: 1 if the slot holds an in-flight store |
| addrKnown | input | ENTRIES | Per slot: 1 if the store's address has been computed |
| killMask | input | ENTRIES | Per slot: 1 if a flush invalidates the slot this cycle |
| stAddr | input | ENTRIES x ADDR_W | Per slot: the store's destination word address |
| loadValid | input | 1 | A load with a computed address is requesting access |
| loadTag | input | TAG_W | Reorder-buffer slot of the requesting load |
| loadAddr | input | ADDR_W | Word address of the load |
| loadGo | output | 1 | The load may start its memory access |
| loadStall | output | 1 | The load must wait |

## Verification
The bench aims at the age boundaries.

- A store in the slot just below the load must block it, and a store in the load's own slot or just above must not. An off-by-one or a non-strict age compare would wrongly stall a load, or release one early.
- A head pointer that has wrapped past the load's slot is exercised. A design that compared raw slot indices would treat wrapped older stores as younger and let a conflicting load through.
- Flush kills and stores with unknown addresses are combined with matching addresses. A design that ignored `killMask` would hold loads behind dead entries. One that trusted unknown addresses would let a load pass a store it may alias.
- Addresses differing only in the top or bottom bit catch a truncated comparator.

// File: rtl/ld_hazard_pkg.sv
package ld_hazard_pkg;

  // Strobes the control half hands to the comparator half each cycle.
  typedef struct packed {
    logic chkEn;       // a load is asking for a verdict
    logic loadOldest;  // the load sits at the head: nothing can be older
  } hzStrobe_t;

endpackage

// File: rtl/ld_hazard_ctrl.sv
module ld_hazard_ctrl
  import ld_hazard_pkg::*;
#(
  parameter int unsigned ENTRIES = 8,
  localparam int unsigned TAG_W  = $clog2(ENTRIES)
) (
  input  logic [TAG_W-1:0]   head,
  input  logic [ENTRIES-1:0] stValid,
  input  logic [ENTRIES-1:0] killMask,
  input  logic               loadValid,
  input  logic [TAG_W-1:0]   loadTag,
  input  logic [ENTRIES-1:0] conflict,
  output hzStrobe_t          strobe,
  output logic [ENTRIES-1:0] candMask,
  output logic               loadGo,
  output logic               loadStall
);

  logic [TAG_W-1:0] loadAge;
  logic [ENTRIES-1:0] olderMask;

  // Distance from the head; wraps because ENTRIES is a power of two.
  assign loadAge = loadTag - head;

  for (genvar i = 0; i < ENTRIES; i++) begin : g_age
    logic [TAG_W-1:0] slotAge;
    assign slotAge      = TAG_W'(i) - head;
    assign olderMask[i] = (slotAge < loadAge);
  end

  // A slot takes part only if it holds a store, survives any flush
  // this cycle, and precedes the load in program order.
  assign candMask = stValid & ~killMask & olderMask;

  always_comb begin
    strobe.chkEn      = loadValid;
    strobe.loadOldest = (loadTag == head);
  end

  assign loadStall = loadValid & (|conflict);
  assign loadGo    = loadValid & ~(|conflict);

endmodule

// File: rtl/ld_hazard_dp.sv
module ld_hazard_dp
  import ld_hazard_pkg::*;
#(
  parameter int unsigned ENTRIES = 8,
  parameter int unsigned ADDR_W  = 32
) (
  input  hzStrobe_t                       strobe,
  input  logic [ENTRIES-1:0]              candMask,
  input  logic [ENTRIES-1:0]              addrKnown,
  input  logic [ENTRIES-1:0][ADDR_W-1:0]  stAddr,
  input  logic [ADDR_W-1:0]               loadAddr,
  output logic [ENTRIES-1:0]              conflict
);

  logic gateOn;
  assign gateOn = strobe.chkEn & ~strobe.loadOldest;

  for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
    logic sameWord;
    assign sameWord    = (stAddr[i] == loadAddr);
    // An unresolved address may alias anything: treat it as a hit.
    assign conflict[i] = gateOn & candMask[i] & (~addrKnown[i] | sameWord);
  end

endmodule

// File: rtl/ld_hazard_gate.sv
module ld_hazard_gate
  import ld_hazard_pkg::*;
#(
  parameter int unsigned ENTRIES = 8,
  parameter int unsigned ADDR_W  = 32,
  localparam int unsigned TAG_W  = $clog2(ENTRIES)
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  logic [TAG_W-1:0]                head,
  input  logic [ENTRIES-1:0]              stValid,
  input  logic [ENTRIES-1:0]              addrKnown,
  input  logic [ENTRIES-1:0]              killMask,
  input  logic [ENTRIES-1:0][ADDR_W-1:0]  stAddr,
  input  logic                            loadValid,
  input  logic [TAG_W-1:0]                loadTag,
  input  logic [ADDR_W-1:0]               loadAddr,
  output logic                            loadGo,
  output logic                            loadStall
);

  hzStrobe_t          strobe;
  logic [ENTRIES-1:0] candMask;
  logic [ENTRIES-1:0] conflict;

  ld_hazard_ctrl #(.ENTRIES(ENTRIES)) u_ctrl (
    .head      (head),
    .stValid   (stValid),
    .killMask  (killMask),
    .loadValid (loadValid),
    .loadTag   (loadTag),
    .conflict  (conflict),
    .strobe    (strobe),
    .candMask  (candMask),
    .loadGo    (loadGo),
    .loadStall (loadStall)
  );

  ld_hazard_dp #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W)) u_dp (
    .strobe    (strobe),
    .candMask  (candMask),
    .addrKnown (addrKnown),
    .stAddr    (stAddr),
    .loadAddr  (loadAddr),
    .conflict  (conflict)
  );

endmodule

// File: rtl/ld_hazard_chk.sv
module ld_hazard_chk #(
  parameter int unsigned ENTRIES = 8,
  localparam int unsigned TAG_W  = $clog2(ENTRIES)
) (
  input logic               clk,
  input logic               rstN,
  input logic [TAG_W-1:0]   head,
  input logic [ENTRIES-1:0] stValid,
  input logic [ENTRIES-1:0] killMask,
  input logic               loadValid,
  input logic [TAG_W-1:0]   loadTag,
  input logic               loadGo,
  input logic               loadStall
);

  initial begin
    // R6
    depth_pow2_chk: assert ((ENTRIES & (ENTRIES - 1)) == 0);
  end

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !loadValid |-> (!loadGo && !loadStall));

  // R9
  one_verdict_chk: assert property (@(posedge clk) disable iff (!rstN)
    loadValid |-> $onehot({loadGo, loadStall}));

  // R5
  oldest_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    (loadValid && loadTag == head) |-> loadGo);

  // R7
  all_killed_chk: assert property (@(posedge clk) disable iff (!rstN)
    (loadValid && (stValid & killMask) == stValid) |-> loadGo);

  // R8
  no_store_chk: assert property (@(posedge clk) disable iff (!rstN)
    (loadValid && stValid == '0) |-> loadGo);

endmodule

bind ld_hazard_gate ld_hazard_chk #(.ENTRIES(ENTRIES)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .head      (head),
  .stValid   (stValid),
  .killMask  (killMask),
  .loadValid (loadValid),
  .loadTag   (loadTag),
  .loadGo    (loadGo),
  .loadStall (loadStall)
);

// File: tb/tb_ld_hazard_gate.sv
module tb_ld_hazard_gate;

  localparam int N  = 8;
  localparam int AW = 32;
  localparam int TW = $clog2(N);

  logic                 clk = 1'b0;
  logic                 rstN = 1'b0;
  logic [TW-1:0]        head = '0;
  logic [N-1:0]         stValid = '0;
  logic [N-1:0]         addrKnown = '0;
  logic [N-1:0]         killMask = '0;
  logic [N-1:0][AW-1:0] stAddr = '0;
  logic                 loadValid = 1'b0;
  logic [TW-1:0]        loadTag = '0;
  logic [AW-1:0]        loadAddr = '0;
  logic                 loadGo, loadStall;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  ld_hazard_gate #(.ENTRIES(N), .ADDR_W(AW)) dut (
    .clk(clk), .rstN(rstN), .head(head), .stValid(stValid),
    .addrKnown(addrKnown), .killMask(killMask), .stAddr(stAddr),
    .loadValid(loadValid), .loadTag(loadTag), .loadAddr(loadAddr),
    .loadGo(loadGo), .loadStall(loadStall)
  );

  // Behavioural reference: walk slots from the head towards the load.
  function automatic bit refBlocked();
    int steps = (int'(loadTag) - int'(head) + N) % N;
    for (int k = 0; k < steps; k++) begin
      int s = (int'(head) + k) % N;
      if (stValid[s] && !killMask[s] && (!addrKnown[s] || stAddr[s] == loadAddr))
        return 1'b1;
    end
    return 1'b0;
  endfunction

  task automatic compare(input string req);
    bit expGo, expStall;
    expStall = loadValid && refBlocked();
    expGo    = loadValid && !expStall;
    checks++;
    if (loadGo !== expGo || loadStall !== expStall) begin
      fails++;
      $display("FAIL %s: go=%b stall=%b expected go=%b stall=%b (head=%0d tag=%0d)",
               req, loadGo, loadStall, expGo, expStall, head, loadTag);
    end
  endtask

  // Inputs change after a rising edge; outputs are sampled at the falling edge.
  task automatic step(input string req);
    @(negedge clk);
    compare(req);
    @(posedge clk);
    #1;
  endtask

  task automatic clearAll();
    stValid = '0; addrKnown = '0; killMask = '0; stAddr = '0;
    loadValid = 1'b0; loadTag = '0; loadAddr = '0; head = '0;
  endtask

  initial begin
    #1000000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    step("R1");                       // reset state, no request
    rstN = 1'b1;
    @(posedge clk); #1;

    // R1: idle with a matching store present
    head = 0; loadTag = 3; loadAddr = 32'h100;
    stValid[1] = 1; addrKnown[1] = 1; stAddr[1] = 32'h100;
    step("R1");

    // R2: older matching store stalls
    loadValid = 1; step("R2");

    // R8: store retires, load released the same cycle
    stValid[1] = 0; step("R8");

    // R3: older store with unknown address
    stValid[2] = 1; addrKnown[2] = 0; stAddr[2] = 32'h999; step("R3");

    // R4: older stores with other known addresses
    addrKnown[2] = 1; stAddr[2] = 32'h104;
    stValid[0] = 1; addrKnown[0] = 1; stAddr[0] = 32'h0FC; step("R4");

    // R5: matching and unknown stores at or above the load's slot
    stValid[3] = 1; addrKnown[3] = 1; stAddr[3] = 32'h100;
    stValid[4] = 1; addrKnown[4] = 0;
    stValid[7] = 1; addrKnown[7] = 1; stAddr[7] = 32'h100; step("R5");

    // R5: load at the head with older-looking slots full of conflicts
    head = 3; step("R5");

    // R6: wrap, head 6, load 1: slot 0 older, slots 2..5 younger
    clearAll(); loadValid = 1; head = 6; loadTag = 1; loadAddr = 32'hABC;
    for (int s = 2; s < 6; s++) begin stValid[s] = 1; addrKnown[s] = 1; stAddr[s] = 32'hABC; end
    step("R6");
    stValid[0] = 1; addrKnown[0] = 1; stAddr[0] = 32'hABC; step("R6");
    stValid[0] = 0; stValid[7] = 1; addrKnown[7] = 0; step("R6");

    // R7: kill the blocking slot in the same cycle
    killMask[7] = 1; step("R7");
    killMask[7] = 0; step("R7");

    // R10: differ only in bit 0 and only in the top bit
    clearAll(); loadValid = 1; head = 2; loadTag = 5; loadAddr = 32'h8000_1234;
    stValid[3] = 1; addrKnown[3] = 1; stAddr[3] = 32'h8000_1235; step("R10");
    stAddr[3] = 32'h0000_1234; step("R10");
    stAddr[3] = 32'h8000_1234; step("R10");

    // R9: random mix of all conditions, compared every cycle
    for (int n = 0; n < 3000; n++) begin
      head      = TW'($urandom);
      loadTag   = TW'($urandom);
      loadValid = ($urandom % 8) != 0;
      loadAddr  = AW'($urandom % 4);
      stValid   = N'($urandom);
      addrKnown = N'($urandom) | N'($urandom);
      killMask  = N'($urandom) & N'($urandom) & N'($urandom);
      for (int s = 0; s < N; s++) stAddr[s] = AW'($urandom % 6);
      step("R9");
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule